// File: doc/BRIEF.md
# Ternary MIN/MAX Sum-of-Products Evaluator

This block evaluates one three-valued function of several three-valued inputs. Each input carries a trit (a value 0, 1 or 2) on two bits. For every input, a set literal gives 2 when the input's value lies in a chosen subset and 0 when it does not. The literals of a product term, together with a constant operand for that term, are joined by MIN. The product terms are then joined by MAX to form the result, which is held in one output register.

The literal subsets and the term constants are parameters. The default instance computes MAX over four terms: MIN(a∈{0,1}, b∈{0,1}), MIN(b∈{0,1}, c∈{1,2}), MIN(1, a∈{0,1}) and MIN(1, b∈{0,1}). Operands arrive as beats on a valid/ready stream and results leave on a second valid/ready stream. A beat is accepted when `in_valid` and `in_ready` are both high. The result sits in the output register until the consumer takes it with `out_ready`. `in_ready` is high while that register is empty or is being drained in the same cycle, so back-pressure from the consumer stops intake with no extra latency. A beat that carries the unused code 3 on any input is flagged instead of evaluated.

Top module: `tern_sop_eval`

## Requirements
- R1: A product term's value is the minimum of its literals and its constant; with the constant at 2 (value encoding 00=0, 01=1, 10=2 on each two-bit field, input a in bits [1:0], b in [3:2], c in [5:4]), a=0,b=0,c=0 yields 2.
- R2: The output value is the maximum over all product terms; a=2,b=0,c=1 yields 2 through the second term alone.
- R3: A literal is 2 when its input lies in the term's subset and 0 otherwise, and a subset of all three values acts as a don't-care; a=2,b=2,c=0 yields 0.
- R4: A constant operand of 1 caps its term at 1; a=2,b=0,c=0 and a=1,b=2,c=2 both yield 1.
- R5: With default parameters, every one of the 27 legal input combinations gives the MAX/MIN value of the four default terms.
- R6: An accepted beat in which any input carries code 3 produces a result with `out_err` high and `out_val` 0; legal beats produce `out_err` low.
- R7: While `rst` is high at a rising edge, `out_valid`, `out_val` and `out_err` are cleared to 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_val` and `out_err` hold their values.
- R9: `in_ready` is high exactly when the output register is empty or `out_ready` is high.
- R10: A beat accepted at one rising edge appears on `out_valid`/`out_val` right after that edge; if no beat is accepted while the held result is taken, `out_valid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take an operand beat |
| in_vals | input | NUM_IN*2 | Packed trits, input k in bits [2k+1:2k] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_val | output | 2 | Ternary result |
| out_err | output | 1 | Result came from a beat with code 3 |

## Verification
The bench first tries single hand-picked vectors. One lights only the first term, one only the second, one only a capped term, and one lights no term. Together these separate MIN from MAX, expose a literal whose subset is wrong, and show whether the constant cap works. It then sweeps all 27 legal combinations, which pins the whole default function. It also sends beats with code 3 on different inputs, showing that the flag follows whichever input is bad. Finally it runs a stretch of random valid and ready activity against a model kept up to date every cycle. That stretch tells apart a stall that holds the result from one that drops or overwrites it.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] trit_t;
  localparam trit_t T_LO  = 2'd0;
  localparam trit_t T_MID = 2'd1;
  localparam trit_t T_HI  = 2'd2;
  localparam trit_t T_BAD = 2'd3;

  function automatic trit_t tmin(trit_t x, trit_t y);
    return (x < y) ? x : y;
  endfunction

  function automatic trit_t tmax(trit_t x, trit_t y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/tern_literal.sv
module tern_literal
  import tern_pkg::*;
#(
  parameter logic [2:0] SET = 3'b111
) (
  input  trit_t val,
  output trit_t lit
);
  always_comb begin
    unique case (val)
      T_LO:    lit = SET[0] ? T_HI : T_LO;
      T_MID:   lit = SET[1] ? T_HI : T_LO;
      T_HI:    lit = SET[2] ? T_HI : T_LO;
      default: lit = T_LO;
    endcase
  end
endmodule

// File: rtl/tern_term.sv
module tern_term
  import tern_pkg::*;
#(
  parameter int               NUM_IN = 3,
  parameter logic [NUM_IN*3-1:0] SETS = '1,
  parameter trit_t            CONST  = T_HI
) (
  input  logic [NUM_IN*2-1:0] vals,
  output trit_t               q
);
  trit_t lits [NUM_IN];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    tern_literal #(.SET(SETS[i*3 +: 3])) u_lit (
      .val(vals[i*2 +: 2]),
      .lit(lits[i])
    );
  end

  always_comb begin
    q = CONST;
    for (int i = 0; i < NUM_IN; i++) q = tmin(q, lits[i]);
  end
endmodule

// File: rtl/tern_max_tree.sv
module tern_max_tree
  import tern_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*2-1:0] terms,
  output trit_t          q
);
  always_comb begin
    q = T_LO;
    for (int i = 0; i < N; i++) q = tmax(q, trit_t'(terms[i*2 +: 2]));
  end
endmodule

// File: rtl/tern_sop_eval.sv
module tern_sop_eval
  import tern_pkg::*;
#(
  parameter int NUM_IN    = 3,
  parameter int NUM_TERMS = 4,
  // subset mask per term per input at [(t*NUM_IN+i)*3 +: 3]; bit k set = value k in subset
  parameter logic [NUM_TERMS*NUM_IN*3-1:0] TERM_SETS =
    36'b111011111_111111011_110011111_111011011,
  // constant operand per term at [t*2 +: 2]
  parameter logic [NUM_TERMS*2-1:0] TERM_CONST = 8'b01_01_10_10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NUM_IN*2-1:0] in_vals,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_val,
  output logic                out_err
);
  localparam int SET_W = NUM_IN * 3;

  logic [NUM_TERMS*2-1:0] term_q;
  logic [NUM_IN-1:0]      bad;
  trit_t                  sop;
  logic                   take;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    tern_term #(
      .NUM_IN(NUM_IN),
      .SETS  (TERM_SETS[t*SET_W +: SET_W]),
      .CONST (trit_t'(TERM_CONST[t*2 +: 2]))
    ) u_term (
      .vals(in_vals),
      .q   (term_q[t*2 +: 2])
    );
  end

  tern_max_tree #(.N(NUM_TERMS)) u_max (
    .terms(term_q),
    .q    (sop)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_bad
    assign bad[i] = (in_vals[i*2 +: 2] == T_BAD);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_val   <= T_LO;
      out_err   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_err   <= |bad;
      out_val   <= (|bad) ? T_LO : sop;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tern_sop_eval_chk.sv
module tern_sop_eval_chk #(
  parameter int NUM_IN = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [NUM_IN*2-1:0] in_vals,
  input logic                out_valid,
  input logic                out_ready,
  input logic [1:0]          out_val,
  input logic                out_err
);
  logic any_bad;
  always_comb begin
    any_bad = 1'b0;
    for (int i = 0; i < NUM_IN; i++) any_bad |= (in_vals[i*2 +: 2] == 2'd3);
  end

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_val) && $stable(out_err));

  p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> out_val == 2'd0);

  p_bad_flag_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && any_bad |=> out_err);

  p_good_noflag_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !any_bad |=> !out_err);

  p_code_legal_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_val != 2'd3);

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_drain_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_empty_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

bind tern_sop_eval tern_sop_eval_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_vals(in_vals), .out_valid(out_valid), .out_ready(out_ready),
  .out_val(out_val), .out_err(out_err)
);

// File: tb/tern_sop_eval_tb.sv
module tern_sop_eval_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       in_ready;
  logic [5:0] in_vals;
  logic       out_valid;
  logic       out_ready;
  logic [1:0] out_val;
  logic       out_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  tern_sop_eval u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_vals(in_vals), .out_valid(out_valid), .out_ready(out_ready),
    .out_val(out_val), .out_err(out_err)
  );

  // literal: 2 inside subset, 0 outside
  function automatic int lit(int x, int lo, int hi);
    return (x >= lo && x <= hi) ? 2 : 0;
  endfunction
  function automatic int mn(int x, int y); return x < y ? x : y; endfunction
  function automatic int mx(int x, int y); return x > y ? x : y; endfunction

  function automatic int ref_f(int a, int b, int c);
    int t0, t1, t2, t3;
    if (a == 3 || b == 3 || c == 3) return 0;
    t0 = mn(lit(a, 0, 1), lit(b, 0, 1));
    t1 = mn(lit(b, 0, 1), lit(c, 1, 2));
    t2 = mn(1, lit(a, 0, 1));
    t3 = mn(1, lit(b, 0, 1));
    return mx(mx(t0, t1), mx(t2, t3));
  endfunction

  // cycle model
  bit m_valid;
  int m_val;
  bit m_err;
  wire m_ready = !m_valid || out_ready;

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 0; m_val <= 0; m_err <= 0;
    end else if (in_valid && m_ready) begin
      m_valid <= 1;
      m_val   <= ref_f(in_vals[1:0], in_vals[3:2], in_vals[5:4]);
      m_err   <= (in_vals[1:0] == 3 || in_vals[3:2] == 3 || in_vals[5:4] == 3);
    end else if (out_ready) begin
      m_valid <= 0;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare against model, sampled at negedge
  task automatic cmp_model();
    check(out_valid == m_valid, "R10 out_valid", out_valid, m_valid);
    check(in_ready == m_ready, "R9 in_ready", in_ready, m_ready);
    if (m_valid) begin
      check(out_val == m_val, "R5 out_val", out_val, m_val);
      check(out_err == m_err, "R6 out_err", out_err, m_err);
    end
  endtask

  // drive one beat with consumer ready, check the result next cycle
  task automatic one(int a, int b, int c, int exp, bit experr, string tag);
    @(negedge clk);
    in_valid  = 1; out_ready = 1;
    in_vals   = {2'(c), 2'(b), 2'(a)};
    @(negedge clk);
    in_valid = 0;
    check(out_valid == 1, tag, out_valid, 1);
    check(out_val == exp, tag, out_val, exp);
    check(out_err == experr, tag, out_err, experr);
  endtask

  initial begin
    rst = 1; in_valid = 0; out_ready = 0; in_vals = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R7 valid reset", out_valid, 0);
    check(out_val == 0, "R7 val reset", out_val, 0);
    check(out_err == 0, "R7 err reset", out_err, 0);
    rst = 0;

    one(0, 0, 0, 2, 0, "R1 min of full-lit term");
    one(2, 0, 1, 2, 0, "R2 max picks second term");
    one(2, 2, 0, 0, 0, "R3 no literal in subset");
    one(2, 0, 0, 1, 0, "R4 capped term");
    one(1, 2, 2, 1, 0, "R4 capped term on a");
    one(3, 0, 0, 0, 1, "R6 bad code on a");
    one(0, 0, 3, 0, 1, "R6 bad code on c");

    // full sweep of legal combinations
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          one(a, b, c, ref_f(a, b, c), 0, "R5 sweep");

    // back-pressure: load a result, stall while new data waits
    @(negedge clk);
    in_valid = 1; out_ready = 0; in_vals = {2'd0, 2'd0, 2'd2}; // a=2,b=0,c=0 -> 1
    @(negedge clk);
    in_vals = {2'd2, 2'd2, 2'd2};
    for (int k = 0; k < 3; k++) begin
      #1;
      check(in_ready == 0, "R9 ready low in stall", in_ready, 0);
      check(out_valid == 1 && out_val == 1, "R8 held during stall", out_val, 1);
      @(negedge clk);
    end
    out_ready = 1;
    #1;
    check(in_ready == 1, "R9 ready with consumer", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    check(out_valid == 1 && out_val == 0, "R10 next beat follows", out_val, 0);
    @(negedge clk);
    check(out_valid == 0, "R10 drained", out_valid, 1'b0);

    // random traffic against the cycle model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      cmp_model();
      in_valid  = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 2) != 0);
      in_vals   = 6'($urandom);
      #1;
      check(in_ready == m_ready, "R9 random ready", in_ready, m_ready);
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule